// File: doc/BRIEF.md
# Message FIFO Index Controller

This block keeps the bookkeeping for a bank of message FIFOs whose storage sits in external memory. Each FIFO carries a head index, a tail index, an occupancy count and an overflow bit. From these the block derives per-FIFO status flags, interrupt requests, and the word addresses at which the protocol engine and software find their next message slot. The memory datapath and the bus-master logic that moves the messages are built elsewhere.

Each FIFO is set up as transmit or receive, with a depth of 1 to 32 messages and a data-only option that halves the message slot. On a transmit FIFO software fills at the head and the engine drains from the tail. On a receive FIFO the engine fills at the head and software drains from the tail. One software strobe and one engine strobe per FIFO are therefore enough to move the two sides, and the direction decides which index each strobe moves.

Top module: `can_msg_fifo_idx`

## Requirements
- R1: After a synchronous active-low reset, every FIFO is a receive FIFO with depth 1 and no data-only storage. All indices and occupancies are zero, and the flags, interrupt requests and reset-busy outputs are all zero.
- R2: A configuration write (cfg_we high) takes effect only while cfg_mode is high. It loads direction (cfg_tx=1 means transmit), depth (cfg_depth+1) and data-only into the FIFO chosen by cfg_sel, and clears that FIFO's indices, occupancy and overflow. When cfg_mode is low the write is ignored.
- R3: On a transmit FIFO, sw_inc advances the head and is ignored when the FIFO is full. eng_inc advances the tail and is ignored when the FIFO is empty. Both indices wrap from depth-1 to 0.
- R4: On a receive FIFO, eng_inc advances the head and sw_inc advances the tail. sw_inc is ignored when the FIFO is empty, and both indices wrap from depth-1 to 0.
- R5: An eng_inc on a full receive FIFO drops the message and sets overflow, using the occupancy at the start of the cycle even if sw_inc reads in the same cycle. Overflow then stays set until ovf_clr; if overflow is set and cleared in the same cycle, the set wins.
- R6: Each FIFO has a 6-bit flag field: bit0 not-empty, bit1 half-full, bit2 full, bit3 overflow, bit4 not-full, bit5 empty. On a transmit FIFO only bit4, bit1 and bit5 can be nonzero, and bit0, bit2 and bit3 read 0.
- R7: On a receive FIFO only bit0, bit1, bit2 and bit3 can be nonzero, and bit4 (not-full) and bit5 read 0.
- R8: Half-full is set when the occupancy is at least ceil(depth/2), in either direction.
- R9: irq[k] is the OR of FIFO k's flag bits ANDed with its 6 enable bits, which use the same bit positions.
- R10: A pulse on fifo_rst_req[k] raises rst_busy[k] in the next cycle. At the end of that busy cycle the FIFO's indices, occupancy and overflow clear and rst_busy falls, and any strobes during the busy cycle are ignored.
- R11: eng_idx and sw_idx give the engine-side and software-side index of the FIFO chosen by eng_sel and sw_sel (engine side is the tail on transmit and the head on receive). Each address equals base_addr + (offset + index) × words. The offset is the sum of the depths of all lower-numbered FIFOs, and words is 2 for data-only and 4 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 1 | Configuration mode is active |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | FIFO targeted by the configuration write |
| cfg_tx | input | 1 | Direction to load, 1 = transmit |
| cfg_depth | input | 5 | Depth minus one to load |
| cfg_donly | input | 1 | Data-only storage to load |
| base_addr | input | ADDR_W | Word address of the message area |
| fifo_rst_req | input | NUM_FIFO | Per-FIFO reset request strobes |
| sw_inc | input | NUM_FIFO | Per-FIFO software increment strobes |
| eng_inc | input | NUM_FIFO | Per-FIFO engine increment strobes |
| ovf_clr | input | NUM_FIFO | Per-FIFO overflow clear strobes |
| irq_en | input | NUM_FIFO*6 | Per-FIFO flag interrupt enables |
| eng_sel | input | SEL_W | FIFO whose engine side is presented |
| sw_sel | input | SEL_W | FIFO whose software side is presented |
| eng_idx | output | 5 | Engine-side index of the selected FIFO |
| sw_idx | output | 5 | Software-side index of the selected FIFO |
| eng_addr | output | ADDR_W | Engine-side slot word address |
| sw_addr | output | ADDR_W | Software-side slot word address |
| flags | output | NUM_FIFO*6 | Per-FIFO status flags |
| irq | output | NUM_FIFO | Per-FIFO interrupt requests |
| rst_busy | output | NUM_FIFO | Per-FIFO reset in progress |

## Verification
The hardest state to reach from the ports is a full receive FIFO of the largest depth that receives an engine store and a software read in the same cycle. Here the store must be dropped and overflow raised while the read still drains one slot. A directed sequence configures a 32-deep receive FIFO, issues 32 engine strobes, and then fires both strobes together. It then checks the engine index, the flags and the overflow hold and clear. Random traffic afterwards reconfigures depths and directions and injects resets during live traffic, so wrap points and cumulative address offsets shift throughout the run.

// File: rtl/can_fifo_pkg.sv
// Shared widths, flag bit positions and helper functions for the
// message FIFO index controller. Assumes depths never exceed 32.
package can_fifo_pkg;
    localparam int IDX_W   = 5;           // index width, depth up to 32
    localparam int CNT_W   = IDX_W + 1;   // occupancy 0..32
    localparam int FLAG_W  = 6;           // flags per FIFO

    localparam int FL_NE    = 0;
    localparam int FL_HF    = 1;
    localparam int FL_FULL  = 2;
    localparam int FL_OVF   = 3;
    localparam int FL_NF    = 4;
    localparam int FL_EMPTY = 5;

    // Words per message slot: data-only slots drop the header words.
    function automatic logic [2:0] msg_words(input logic donly);
        return donly ? 3'd2 : 3'd4;
    endfunction

    // Circular index step, wrapping after the last configured slot.
    function automatic logic [IDX_W-1:0] idx_step(input logic [IDX_W-1:0] cur,
                                                  input logic [IDX_W-1:0] last);
        return (cur == last) ? '0 : cur + IDX_W'(1);
    endfunction
endpackage

// File: rtl/can_fifo_slot.sv
// One FIFO's index state: configuration, head/tail, occupancy, overflow,
// reset handshake, flags and interrupt request. Assumes cfg_wr is already
// qualified by configuration mode and selection.
module can_fifo_slot
    import can_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_tx,
    input  logic [IDX_W-1:0]  cfg_depth_m1,
    input  logic              cfg_donly,
    input  logic              rst_req,
    input  logic              sw_inc,
    input  logic              eng_inc,
    input  logic              ovf_clr,
    input  logic [FLAG_W-1:0] irq_en,
    output logic [IDX_W-1:0]  depth_m1,
    output logic              donly,
    output logic [IDX_W-1:0]  eng_idx,
    output logic [IDX_W-1:0]  sw_idx,
    output logic [FLAG_W-1:0] flags,
    output logic              irq,
    output logic              busy
);
    logic              tx_q;
    logic [IDX_W-1:0]  dm1_q;
    logic              don_q;
    logic [IDX_W-1:0]  head_q;
    logic [IDX_W-1:0]  tail_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              ovf_q;
    logic              busy_q;

    logic [CNT_W-1:0]  depth;
    logic [CNT_W-1:0]  half_thr;
    logic              is_full;
    logic              is_empty;
    logic              head_adv;
    logic              tail_adv;
    logic              ovf_set;
    logic              wipe;

    // Derived depth, thresholds and strobe qualification.
    always_comb begin
        depth    = CNT_W'(dm1_q) + CNT_W'(1);
        half_thr = (depth + CNT_W'(1)) >> 1;
        is_full  = (cnt_q == depth);
        is_empty = (cnt_q == '0);
        head_adv = (tx_q ? sw_inc : eng_inc) && !is_full;
        tail_adv = (tx_q ? eng_inc : sw_inc) && !is_empty;
        ovf_set  = !tx_q && eng_inc && is_full;
        wipe     = busy_q || cfg_wr;
    end

    // Configuration registers, loaded only by qualified writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q  <= 1'b0;
            dm1_q <= '0;
            don_q <= 1'b0;
        end else if (cfg_wr) begin
            tx_q  <= cfg_tx;
            dm1_q <= cfg_depth_m1;
            don_q <= cfg_donly;
        end
    end

    // Reset handshake: busy for exactly the cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= rst_req;
    end

    // Head and tail indices with wrap at the configured depth.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (head_adv) head_q <= idx_step(head_q, dm1_q);
            if (tail_adv) tail_q <= idx_step(tail_q, dm1_q);
        end
    end

    // Occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            cnt_q <= '0;
        end else begin
            case ({head_adv, tail_adv})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Sticky overflow; a new overflow beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe)  ovf_q <= 1'b0;
        else if (ovf_set)    ovf_q <= 1'b1;
        else if (ovf_clr)    ovf_q <= 1'b0;
    end

    // Direction-dependent flags and index outputs.
    always_comb begin
        flags           = '0;
        flags[FL_NE]    = !tx_q && !is_empty;
        flags[FL_HF]    = (cnt_q >= half_thr);
        flags[FL_FULL]  = !tx_q && is_full;
        flags[FL_OVF]   = !tx_q && ovf_q;
        flags[FL_NF]    = tx_q && !is_full;
        flags[FL_EMPTY] = tx_q && is_empty;
        eng_idx         = tx_q ? tail_q : head_q;
        sw_idx          = tx_q ? head_q : tail_q;
    end

    assign irq      = |(flags & irq_en);
    assign busy     = busy_q;
    assign depth_m1 = dm1_q;
    assign donly    = don_q;
endmodule

// File: rtl/can_fifo_addr.sv
// Slot address generation: accumulates FIFO depths into per-FIFO offsets
// and turns the selected engine and software indices into word addresses.
// Assumes the select inputs stay below NUM_FIFO.
module can_fifo_addr
    import can_fifo_pkg::*;
#(
    parameter int NUM_FIFO = 4,
    parameter int ADDR_W   = 32,
    parameter int SEL_W    = 2
) (
    input  logic [NUM_FIFO*IDX_W-1:0] dm1_flat,
    input  logic [NUM_FIFO-1:0]       donly,
    input  logic [NUM_FIFO*IDX_W-1:0] eng_idx_flat,
    input  logic [NUM_FIFO*IDX_W-1:0] sw_idx_flat,
    input  logic [SEL_W-1:0]          eng_sel,
    input  logic [SEL_W-1:0]          sw_sel,
    input  logic [ADDR_W-1:0]         base_addr,
    output logic [IDX_W-1:0]          eng_idx,
    output logic [IDX_W-1:0]          sw_idx,
    output logic [ADDR_W-1:0]         eng_addr,
    output logic [ADDR_W-1:0]         sw_addr
);
    localparam int OFF_W = $clog2(NUM_FIFO * (1 << IDX_W) + 1);

    logic [OFF_W-1:0] off_arr [NUM_FIFO];

    // Running sum of the depths of all lower-numbered FIFOs.
    always_comb begin : p_offsets
        logic [OFF_W-1:0] acc;
        acc = '0;
        for (int k = 0; k < NUM_FIFO; k++) begin
            off_arr[k] = acc;
            acc = acc + OFF_W'(dm1_flat[k*IDX_W +: IDX_W]) + OFF_W'(1);
        end
    end

    // Select the requested indices and scale into word addresses.
    always_comb begin
        eng_idx  = eng_idx_flat[eng_sel*IDX_W +: IDX_W];
        sw_idx   = sw_idx_flat[sw_sel*IDX_W +: IDX_W];
        eng_addr = base_addr + (ADDR_W'(off_arr[eng_sel]) + ADDR_W'(eng_idx))
                               * ADDR_W'(msg_words(donly[eng_sel]));
        sw_addr  = base_addr + (ADDR_W'(off_arr[sw_sel]) + ADDR_W'(sw_idx))
                               * ADDR_W'(msg_words(donly[sw_sel]));
    end
endmodule

// File: rtl/can_msg_fifo_idx.sv
// Top of the message FIFO index controller: one slot per FIFO plus the
// shared address generator. Assumes NUM_FIFO >= 2 and registered strobes
// from the engine and software side.
module can_msg_fifo_idx
    import can_fifo_pkg::*;
#(
    parameter int NUM_FIFO = 4,
    parameter int ADDR_W   = 32,
    parameter int SEL_W    = $clog2(NUM_FIFO)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_mode,
    input  logic                       cfg_we,
    input  logic [SEL_W-1:0]           cfg_sel,
    input  logic                       cfg_tx,
    input  logic [4:0]                 cfg_depth,
    input  logic                       cfg_donly,
    input  logic [ADDR_W-1:0]          base_addr,
    input  logic [NUM_FIFO-1:0]        fifo_rst_req,
    input  logic [NUM_FIFO-1:0]        sw_inc,
    input  logic [NUM_FIFO-1:0]        eng_inc,
    input  logic [NUM_FIFO-1:0]        ovf_clr,
    input  logic [NUM_FIFO*6-1:0]      irq_en,
    input  logic [SEL_W-1:0]           eng_sel,
    input  logic [SEL_W-1:0]           sw_sel,
    output logic [4:0]                 eng_idx,
    output logic [4:0]                 sw_idx,
    output logic [ADDR_W-1:0]          eng_addr,
    output logic [ADDR_W-1:0]          sw_addr,
    output logic [NUM_FIFO*6-1:0]      flags,
    output logic [NUM_FIFO-1:0]        irq,
    output logic [NUM_FIFO-1:0]        rst_busy
);
    logic [NUM_FIFO*IDX_W-1:0] dm1_flat;
    logic [NUM_FIFO-1:0]       donly_vec;
    logic [NUM_FIFO*IDX_W-1:0] eng_idx_flat;
    logic [NUM_FIFO*IDX_W-1:0] sw_idx_flat;

    for (genvar k = 0; k < NUM_FIFO; k++) begin : g_slot
        logic cfg_hit;
        // Configuration write qualified by mode and selection.
        assign cfg_hit = cfg_mode && cfg_we && (cfg_sel == SEL_W'(k));

        can_fifo_slot i_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .cfg_wr       (cfg_hit),
            .cfg_tx       (cfg_tx),
            .cfg_depth_m1 (cfg_depth),
            .cfg_donly    (cfg_donly),
            .rst_req      (fifo_rst_req[k]),
            .sw_inc       (sw_inc[k]),
            .eng_inc      (eng_inc[k]),
            .ovf_clr      (ovf_clr[k]),
            .irq_en       (irq_en[k*FLAG_W +: FLAG_W]),
            .depth_m1     (dm1_flat[k*IDX_W +: IDX_W]),
            .donly        (donly_vec[k]),
            .eng_idx      (eng_idx_flat[k*IDX_W +: IDX_W]),
            .sw_idx       (sw_idx_flat[k*IDX_W +: IDX_W]),
            .flags        (flags[k*FLAG_W +: FLAG_W]),
            .irq          (irq[k]),
            .busy         (rst_busy[k])
        );
    end

    can_fifo_addr #(
        .NUM_FIFO (NUM_FIFO),
        .ADDR_W   (ADDR_W),
        .SEL_W    (SEL_W)
    ) i_addr (
        .dm1_flat     (dm1_flat),
        .donly        (donly_vec),
        .eng_idx_flat (eng_idx_flat),
        .sw_idx_flat  (sw_idx_flat),
        .eng_sel      (eng_sel),
        .sw_sel       (sw_sel),
        .base_addr    (base_addr),
        .eng_idx      (eng_idx),
        .sw_idx       (sw_idx),
        .eng_addr     (eng_addr),
        .sw_addr      (sw_addr)
    );
endmodule

// File: rtl/can_msg_fifo_idx_chk.sv
// Property checker for the message FIFO index controller, attached by bind.
// Observes ports only.
module can_msg_fifo_idx_chk #(
    parameter int NUM_FIFO = 4,
    parameter int SEL_W    = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_mode,
    input logic                  cfg_we,
    input logic [SEL_W-1:0]      cfg_sel,
    input logic [NUM_FIFO-1:0]   sw_inc,
    input logic [NUM_FIFO-1:0]   ovf_clr,
    input logic [NUM_FIFO*6-1:0] flags,
    input logic [NUM_FIFO-1:0]   irq,
    input logic [NUM_FIFO-1:0]   rst_busy
);
    for (genvar k = 0; k < NUM_FIFO; k++) begin : g_chk
        logic [5:0] f;
        logic       cfg_hit;
        assign f       = flags[k*6 +: 6];
        assign cfg_hit = cfg_mode && cfg_we && (cfg_sel == SEL_W'(k));

        // R6 R7: transmit-only and receive-only flags never coexist
        p_dir_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (f[4] || f[5]) |-> !(f[0] || f[2] || f[3]));

        // R8: a full FIFO is always at least half full
        p_full_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (f[2] || (f[5] == 1'b0 && f[4] == 1'b0 && f[0] == 1'b0 && f[1])) |-> f[1]);

        // R5: overflow holds until cleared, reset or reconfigured
        p_ovf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (f[3] && !ovf_clr[k] && !rst_busy[k] && !cfg_hit) |=> f[3]);

        // R10: after the busy cycle the FIFO is empty with no overflow
        p_busy_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
            rst_busy[k] |=> (!f[0] && !f[2] && !f[3]));

        // R3: engine strobes on an empty transmit FIFO change nothing
        p_tx_empty_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (f[5] && !sw_inc[k] && !rst_busy[k] && !cfg_hit) |=> f[5]);

        // R9: an interrupt request needs some active flag
        p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
            irq[k] |-> (f != 6'd0));
    end
endmodule

bind can_msg_fifo_idx can_msg_fifo_idx_chk #(
    .NUM_FIFO (NUM_FIFO),
    .SEL_W    (SEL_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_mode (cfg_mode),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .sw_inc   (sw_inc),
    .ovf_clr  (ovf_clr),
    .flags    (flags),
    .irq      (irq),
    .rst_busy (rst_busy)
);

// File: tb/test_can_msg_fifo_idx.sv
module test_can_msg_fifo_idx;
    localparam int N  = 4;
    localparam int AW = 32;
    localparam int SW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_mode = 1'b0, cfg_we = 1'b0, cfg_tx = 1'b0, cfg_donly = 1'b0;
    logic [SW-1:0]   cfg_sel = '0, eng_sel = '0, sw_sel = '0;
    logic [4:0]      cfg_depth = '0;
    logic [AW-1:0]   base_addr = 32'h0000_1000;
    logic [N-1:0]    fifo_rst_req = '0, sw_inc = '0, eng_inc = '0, ovf_clr = '0;
    logic [N*6-1:0]  irq_en = '0;
    logic [4:0]      eng_idx, sw_idx;
    logic [AW-1:0]   eng_addr, sw_addr;
    logic [N*6-1:0]  flags;
    logic [N-1:0]    irq, rst_busy;

    int total = 0, bad = 0;
    bit finished = 0;

    int m_tx[N], m_dm1[N], m_don[N], m_head[N], m_tail[N], m_cnt[N], m_ovf[N], m_busy[N];

    always #10 clk = ~clk;   // 50 MHz

    can_msg_fifo_idx #(.NUM_FIFO(N), .ADDR_W(AW)) i_can_msg_fifo_idx (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_tx(cfg_tx), .cfg_depth(cfg_depth),
        .cfg_donly(cfg_donly), .base_addr(base_addr), .fifo_rst_req(fifo_rst_req),
        .sw_inc(sw_inc), .eng_inc(eng_inc), .ovf_clr(ovf_clr), .irq_en(irq_en),
        .eng_sel(eng_sel), .sw_sel(sw_sel), .eng_idx(eng_idx), .sw_idx(sw_idx),
        .eng_addr(eng_addr), .sw_addr(sw_addr), .flags(flags), .irq(irq),
        .rst_busy(rst_busy)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, got, exp);
        end
    endtask

    function automatic logic [5:0] exp_flags(input int k);
        int d = m_dm1[k] + 1;
        logic [5:0] f = '0;
        f[0] = !m_tx[k] && m_cnt[k] != 0;
        f[1] = m_cnt[k] >= (d + 1) / 2;
        f[2] = !m_tx[k] && m_cnt[k] == d;
        f[3] = !m_tx[k] && m_ovf[k] != 0;
        f[4] = m_tx[k] && m_cnt[k] < d;
        f[5] = m_tx[k] && m_cnt[k] == 0;
        return f;
    endfunction

    function automatic logic [31:0] exp_addr(input int k, input int idx);
        int off = 0;
        for (int j = 0; j < k; j++) off += m_dm1[j] + 1;
        return base_addr + 32'((off + idx) * (m_don[k] ? 2 : 4));
    endfunction

    function automatic int wrap(input int i, input int last);
        return (i == last) ? 0 : i + 1;
    endfunction

    // Next-state model from the requirements, applied with current inputs.
    task automatic model_step();
        for (int k = 0; k < N; k++) begin
            bit wr = cfg_mode && cfg_we && (int'(cfg_sel) == k);
            int d = m_dm1[k] + 1;
            bit full = (m_cnt[k] == d);
            bit empty = (m_cnt[k] == 0);
            int was_busy = m_busy[k];
            bit hadv, tadv;
            m_busy[k] = fifo_rst_req[k];
            if (wr) begin
                m_tx[k] = cfg_tx; m_dm1[k] = cfg_depth; m_don[k] = cfg_donly;
            end
            if (was_busy != 0 || wr) begin
                m_head[k] = 0; m_tail[k] = 0; m_cnt[k] = 0; m_ovf[k] = 0;
            end else begin
                hadv = (m_tx[k] ? sw_inc[k] : eng_inc[k]) && !full;
                tadv = (m_tx[k] ? eng_inc[k] : sw_inc[k]) && !empty;
                if (hadv) m_head[k] = wrap(m_head[k], m_dm1[k]);
                if (tadv) m_tail[k] = wrap(m_tail[k], m_dm1[k]);
                m_cnt[k] += int'(hadv) - int'(tadv);
                if (!m_tx[k] && eng_inc[k] && full) m_ovf[k] = 1;
                else if (ovf_clr[k]) m_ovf[k] = 0;
            end
        end
    endtask

    task automatic compare_all();
        int e = int'(eng_sel);
        int s = int'(sw_sel);
        int ei = m_tx[e] ? m_tail[e] : m_head[e];
        int si = m_tx[s] ? m_head[s] : m_tail[s];
        for (int k = 0; k < N; k++) begin
            chk(m_tx[k] ? "R6 flags" : "R7 flags", 32'(flags[k*6 +: 6]), 32'(exp_flags(k)));
            chk("R9 irq", 32'(irq[k]), 32'(|(exp_flags(k) & irq_en[k*6 +: 6])));
            chk("R10 busy", 32'(rst_busy[k]), 32'(m_busy[k]));
        end
        chk(m_tx[e] ? "R3 eng_idx" : "R4 eng_idx", 32'(eng_idx), 32'(ei));
        chk(m_tx[s] ? "R3 sw_idx" : "R4 sw_idx", 32'(sw_idx), 32'(si));
        chk("R11 eng_addr", eng_addr, exp_addr(e, ei));
        chk("R11 sw_addr", sw_addr, exp_addr(s, si));
    endtask

    task automatic tick();
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic quiet();
        cfg_mode = 0; cfg_we = 0; fifo_rst_req = '0; sw_inc = '0; eng_inc = '0; ovf_clr = '0;
    endtask

    task automatic cfg(input int k, input bit tx, input int dm1, input bit don);
        quiet();
        cfg_mode = 1; cfg_we = 1; cfg_sel = SW'(k); cfg_tx = tx;
        cfg_depth = 5'(dm1); cfg_donly = don;
        tick();
        quiet();
    endtask

    task automatic pulse(input logic [N-1:0] s, input logic [N-1:0] e);
        quiet(); sw_inc = s; eng_inc = e; tick(); quiet();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R1..: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < N; k++) begin
            m_tx[k] = 0; m_dm1[k] = 0; m_don[k] = 0; m_head[k] = 0;
            m_tail[k] = 0; m_cnt[k] = 0; m_ovf[k] = 0; m_busy[k] = 0;
        end
        irq_en = '1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 flags", 32'(flags), 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 busy", 32'(rst_busy), 0);
        chk("R1 eng_idx", 32'(eng_idx), 0);
        compare_all();

        // R2: write outside configuration mode is ignored
        quiet(); cfg_we = 1; cfg_sel = 1; cfg_tx = 1; cfg_depth = 7; tick(); quiet();
        chk("R2 ignored write", 32'(flags[6 +: 6]), 0);

        cfg(0, 1, 3, 0);
        cfg(1, 0, 31, 1);
        cfg(2, 1, 4, 0);
        cfg(3, 0, 1, 1);
        chk("R2 tx applied", 32'(flags[0 +: 6]), 32'h30);

        // R3: transmit fill past full, wrap, then drain past empty
        eng_sel = 0; sw_sel = 0;
        for (int i = 0; i < 5; i++) pulse(4'b0001, 4'b0000);
        chk("R3 head wrapped, extra push ignored", 32'(sw_idx), 0);
        chk("R3 not-full low", 32'(flags[4]), 0);
        for (int i = 0; i < 5; i++) pulse(4'b0000, 4'b0001);
        chk("R3 empty after drain", 32'(flags[5]), 1);

        // R8: depth 5 half threshold is 3
        pulse(4'b0100, 0); pulse(4'b0100, 0);
        chk("R8 two of five", 32'(flags[12 + 1]), 0);
        pulse(4'b0100, 0);
        chk("R8 three of five", 32'(flags[12 + 1]), 1);

        // R5: 32-deep receive FIFO, store plus read when full
        eng_sel = 1; sw_sel = 1;
        for (int i = 0; i < 32; i++) pulse(0, 4'b0010);
        chk("R5 full", 32'(flags[6 + 2]), 1);
        pulse(4'b0010, 4'b0010);
        chk("R5 store dropped", 32'(eng_idx), 0);
        chk("R5 ovf set", 32'(flags[6 + 3]), 1);
        chk("R4 read advanced tail", 32'(sw_idx), 1);
        pulse(0, 4'b0010);
        chk("R5 ovf held", 32'(flags[6 + 3]), 1);
        quiet(); ovf_clr = 4'b0010; eng_inc = 4'b0010; tick(); quiet();
        chk("R5 set beats clear", 32'(flags[6 + 3]), 1);
        quiet(); ovf_clr = 4'b0010; tick(); quiet();
        chk("R5 cleared", 32'(flags[6 + 3]), 0);

        // R4: receive read on empty ignored
        eng_sel = 3; sw_sel = 3;
        pulse(4'b1000, 0);
        chk("R4 empty read ignored", 32'(sw_idx), 0);
        pulse(0, 4'b1000);

        // R10: reset request, strobes during busy ignored
        quiet(); fifo_rst_req = 4'b1000; tick(); quiet();
        chk("R10 busy raised", 32'(rst_busy[3]), 1);
        eng_inc = 4'b1000; tick(); quiet();
        chk("R10 busy fell", 32'(rst_busy[3]), 0);
        chk("R10 state cleared", 32'(eng_idx), 0);

        // Random traffic with periodic reconfiguration
        for (int c = 0; c < 4000; c++) begin
            quiet();
            if (c % 200 == 0) begin
                cfg_mode = 1; cfg_we = 1; cfg_sel = SW'($urandom % N);
                cfg_tx = 1'($urandom % 2); cfg_donly = 1'($urandom % 2);
                cfg_depth = 5'(($urandom % 4 == 0) ? $urandom % 32 : $urandom % 6);
                base_addr = $urandom & 32'hFFFF_FFF0;
            end else begin
                if ($urandom % 40 == 0) begin
                    cfg_we = 1; cfg_sel = SW'($urandom % N); cfg_tx = 1'($urandom % 2);
                    cfg_depth = 5'($urandom % 32);
                end
                for (int k = 0; k < N; k++) begin
                    sw_inc[k] = ($urandom % 3 == 0);
                    eng_inc[k] = ($urandom % 3 == 0);
                    ovf_clr[k] = ($urandom % 25 == 0);
                    fifo_rst_req[k] = ($urandom % 97 == 0);
                end
            end
            if ($urandom % 8 == 0) irq_en = 24'($urandom);
            eng_sel = SW'($urandom % N);
            sw_sel = SW'($urandom % N);
            tick();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule